// File: doc/BRIEF.md
# Transactional Ring Pointer Manager

This block keeps the address pointers of a circular word store whose depth is a power of two. Records are written one word at a time through a speculative write pointer. The words become visible to the reader only when the record is committed. If the record is abandoned, either through an abort from the protocol engine or through an overrun abort, the speculative pointer snaps back to the last committed position and the words it had claimed are returned.

A fourth pointer can be loaded from the speculative pointer and stepped on its own. It is used to back-fill slots that were reserved earlier in the record. The block also reports how many words are free, and gives the read pointer plus one as a combinational output, so that a synchronous memory can be addressed one word ahead without losing a cycle. The memory itself and the record parsing sit outside the block.

Top module: `ringPtrMgr`

## Requirements
- R1: After reset, readPtr, commitPtr, rawPtr and extraPtr are all 0, and freeWords equals DEPTH.
- R2: A cycle with writeOk high advances rawPtr by one, modulo DEPTH, and lowers freeWords by one. It does not change commitPtr.
- R3: A commit copies the value that rawPtr holds before the edge into commitPtr. An accepted write in the same cycle still advances rawPtr, and that word stays uncommitted.
- R4: abortReq or overrunAbort reloads rawPtr from commitPtr. It also raises freeWords by the number of words accepted since the last commit. A rollback takes priority over a commit and over a write in the same cycle.
- R5: extraLoad copies rawPtr into extraPtr. extraStep advances extraPtr by one, and extraLoad wins when both are high. Neither command changes rawPtr.
- R6: readStep advances readPtr by one, modulo DEPTH. readPtrNext always equals readPtr+1 modulo DEPTH, with no register delay.
- R7: Each readStep raises freeWords by one. A readStep and an accepted write in the same cycle leave freeWords unchanged.
- R8: eraseReq returns every pointer to 0 and freeWords to DEPTH, whatever else is requested in that cycle.
- R9: Every pointer wraps from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| readStep | input | 1 | A valid word was read |
| writeOk | input | 1 | A word was accepted at rawPtr |
| commitReq | input | 1 | Make the speculative record visible |
| abortReq | input | 1 | Protocol abort, roll back |
| overrunAbort | input | 1 | Overrun abort, roll back |
| extraLoad | input | 1 | Load extraPtr from rawPtr |
| extraStep | input | 1 | Advance extraPtr |
| eraseReq | input | 1 | Synchronous clear of all state |
| readPtr | output | AW | Read pointer |
| readPtrNext | output | AW | readPtr+1, combinational |
| commitPtr | output | AW | Committed write pointer |
| rawPtr | output | AW | Speculative write pointer |
| extraPtr | output | AW | Back-fill write pointer |
| freeWords | output | AW+1 | Free words |

## Verification
Three collisions matter. The first is a commit that lands in the same cycle as a write. The bench then rolls back and checks that only the one word written in the commit cycle is returned to freeWords. The second is a rollback that coincides with both a commit and a write, and the bench checks that the rollback wins. The third is a read that coincides with a write, and the bench checks that freeWords holds still while both pointers step. Each case is driven as a single-cycle pulse, and the pointers and count are judged on the following falling edge against values computed by hand.

// File: rtl/ringPtrPkg.sv
package ringPtrPkg;
  typedef struct packed {
    logic erase;
    logic rollback;
    logic commit;
    logic rawAdv;
    logic rdAdv;
    logic extraLoad;
    logic extraAdv;
  } ptrStrobes_t;
endpackage

// File: rtl/ringPtrCtl.sv
module ringPtrCtl
  import ringPtrPkg::*;
(
  input  logic        readStep,
  input  logic        writeOk,
  input  logic        commitReq,
  input  logic        abortReq,
  input  logic        overrunAbort,
  input  logic        extraLoad,
  input  logic        extraStep,
  input  logic        eraseReq,
  output ptrStrobes_t strobes
);
  logic rollbackReq;

  assign rollbackReq = abortReq | overrunAbort;

  // Priority: erase > rollback > commit/write; extra load > extra step
  always_comb begin
    strobes.erase     = eraseReq;
    strobes.rollback  = rollbackReq & ~eraseReq;
    strobes.commit    = commitReq & ~eraseReq & ~rollbackReq;
    strobes.rawAdv    = writeOk & ~eraseReq & ~rollbackReq;
    strobes.rdAdv     = readStep & ~eraseReq;
    strobes.extraLoad = extraLoad & ~eraseReq;
    strobes.extraAdv  = extraStep & ~eraseReq & ~extraLoad;
  end
endmodule

// File: rtl/ringPtrDp.sv
module ringPtrDp
  import ringPtrPkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  ptrStrobes_t strobes,
  output logic [AW-1:0] readPtr,
  output logic [AW-1:0] readPtrNext,
  output logic [AW-1:0] commitPtr,
  output logic [AW-1:0] rawPtr,
  output logic [AW-1:0] extraPtr,
  output logic [CW-1:0] freeWords
);
  localparam logic [CW-1:0] FULL_FREE = CW'(DEPTH);
  localparam logic [AW-1:0] ONE_PTR   = AW'(1);

  logic [CW-1:0] pendingCnt;
  logic [CW:0]   freeNext;

  assign readPtrNext = readPtr + ONE_PTR;

  always_comb begin
    freeNext = {1'b0, freeWords};
    if (strobes.rdAdv)    freeNext = freeNext + 1'b1;
    if (strobes.rollback) freeNext = freeNext + {1'b0, pendingCnt};
    if (strobes.rawAdv)   freeNext = freeNext - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPtr    <= '0;
      commitPtr  <= '0;
      rawPtr     <= '0;
      extraPtr   <= '0;
      pendingCnt <= '0;
      freeWords  <= FULL_FREE;
    end else if (strobes.erase) begin
      readPtr    <= '0;
      commitPtr  <= '0;
      rawPtr     <= '0;
      extraPtr   <= '0;
      pendingCnt <= '0;
      freeWords  <= FULL_FREE;
    end else begin
      freeWords <= freeNext[CW-1:0];
      if (strobes.rdAdv) readPtr <= readPtrNext;
      if (strobes.commit) commitPtr <= rawPtr;
      if (strobes.rollback) begin
        rawPtr     <= commitPtr;
        pendingCnt <= '0;
      end else begin
        if (strobes.rawAdv) rawPtr <= rawPtr + ONE_PTR;
        if (strobes.commit) pendingCnt <= CW'(strobes.rawAdv);
        else if (strobes.rawAdv) pendingCnt <= pendingCnt + 1'b1;
      end
      if (strobes.extraLoad) extraPtr <= rawPtr;
      else if (strobes.extraAdv) extraPtr <= extraPtr + ONE_PTR;
    end
  end

  p_raw_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rawAdv |=> rawPtr == $past(rawPtr) + ONE_PTR);

  p_commit_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> commitPtr == $past(rawPtr));

  p_rollback_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rollback |=> rawPtr == $past(commitPtr));

  p_extra_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.extraLoad |=> extraPtr == $past(rawPtr));

  p_free_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    freeWords <= FULL_FREE);

  p_erase_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.erase |=> (freeWords == FULL_FREE) && (readPtr == '0) && (rawPtr == '0));
endmodule

// File: rtl/ringPtrMgr.sv
module ringPtrMgr
  import ringPtrPkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          readStep,
  input  logic          writeOk,
  input  logic          commitReq,
  input  logic          abortReq,
  input  logic          overrunAbort,
  input  logic          extraLoad,
  input  logic          extraStep,
  input  logic          eraseReq,
  output logic [AW-1:0] readPtr,
  output logic [AW-1:0] readPtrNext,
  output logic [AW-1:0] commitPtr,
  output logic [AW-1:0] rawPtr,
  output logic [AW-1:0] extraPtr,
  output logic [CW-1:0] freeWords
);
  ptrStrobes_t strobes;

  initial begin
    assert (DEPTH >= 32 && DEPTH <= 4096 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("DEPTH must be a power of two in 32..4096");
  end

  ringPtrCtl uCtl (
    .readStep(readStep), .writeOk(writeOk), .commitReq(commitReq),
    .abortReq(abortReq), .overrunAbort(overrunAbort), .extraLoad(extraLoad),
    .extraStep(extraStep), .eraseReq(eraseReq), .strobes(strobes)
  );

  ringPtrDp #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .readPtr(readPtr), .readPtrNext(readPtrNext), .commitPtr(commitPtr),
    .rawPtr(rawPtr), .extraPtr(extraPtr), .freeWords(freeWords)
  );

  p_next_comb_r6: assert property (@(posedge clk) disable iff (!rstN)
    readPtrNext == AW'(readPtr + 1'b1));
endmodule

// File: tb/sim_ringPtrMgr.sv
`timescale 1ns/1ps
module sim_ringPtrMgr;
  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  localparam int B_RD = 0, B_WR = 1, B_CM = 2, B_AB = 3, B_OV = 4,
                 B_XL = 5, B_XS = 6, B_ER = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readStep = 0, writeOk = 0, commitReq = 0, abortReq = 0;
  logic overrunAbort = 0, extraLoad = 0, extraStep = 0, eraseReq = 0;
  logic [AW-1:0] readPtr, readPtrNext, commitPtr, rawPtr, extraPtr;
  logic [CW-1:0] freeWords;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ringPtrMgr #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .readStep(readStep), .writeOk(writeOk),
    .commitReq(commitReq), .abortReq(abortReq), .overrunAbort(overrunAbort),
    .extraLoad(extraLoad), .extraStep(extraStep), .eraseReq(eraseReq),
    .readPtr(readPtr), .readPtrNext(readPtrNext), .commitPtr(commitPtr),
    .rawPtr(rawPtr), .extraPtr(extraPtr), .freeWords(freeWords)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle of requests at a falling edge; results visible at the next falling edge
  task automatic step(input logic [7:0] v);
    readStep = v[B_RD]; writeOk = v[B_WR]; commitReq = v[B_CM];
    abortReq = v[B_AB]; overrunAbort = v[B_OV]; extraLoad = v[B_XL];
    extraStep = v[B_XS]; eraseReq = v[B_ER];
    @(negedge clk);
    readStep = 0; writeOk = 0; commitReq = 0; abortReq = 0;
    overrunAbort = 0; extraLoad = 0; extraStep = 0; eraseReq = 0;
  endtask

  task automatic t_reset;
    chk("R1 readPtr", readPtr, 0);
    chk("R1 commitPtr", commitPtr, 0);
    chk("R1 rawPtr", rawPtr, 0);
    chk("R1 extraPtr", extraPtr, 0);
    chk("R1 freeWords", freeWords, DEPTH);
  endtask

  task automatic t_write_commit;
    for (int i = 0; i < 3; i++) step(8'(1 << B_WR));
    chk("R2 rawPtr", rawPtr, 3);
    chk("R2 commitPtr held", commitPtr, 0);
    chk("R2 freeWords", freeWords, 29);
    step(8'(1 << B_CM));
    chk("R3 commitPtr", commitPtr, 3);
    chk("R3 freeWords", freeWords, 29);
  endtask

  task automatic t_rollback;
    step(8'(1 << B_WR)); step(8'(1 << B_WR));
    step(8'(1 << B_AB));
    chk("R4 abort rawPtr", rawPtr, 3);
    chk("R4 abort freeWords", freeWords, 29);
    step(8'(1 << B_WR));
    step(8'(1 << B_OV));
    chk("R4 overrun rawPtr", rawPtr, 3);
    chk("R4 overrun freeWords", freeWords, 29);
    step(8'(1 << B_WR));
    step(8'((1 << B_AB) | (1 << B_CM) | (1 << B_WR)));
    chk("R4 priority rawPtr", rawPtr, 3);
    chk("R4 priority commitPtr", commitPtr, 3);
    chk("R4 priority freeWords", freeWords, 29);
  endtask

  task automatic t_commit_with_write;
    step(8'(1 << B_WR));
    step(8'((1 << B_CM) | (1 << B_WR)));
    chk("R3 same-cycle commitPtr", commitPtr, 4);
    chk("R3 same-cycle rawPtr", rawPtr, 5);
    chk("R3 same-cycle freeWords", freeWords, 27);
    step(8'(1 << B_AB));
    chk("R4 partial rawPtr", rawPtr, 4);
    chk("R4 partial freeWords", freeWords, 28);
  endtask

  task automatic t_extra;
    step(8'(1 << B_XL));
    chk("R5 load", extraPtr, 4);
    step(8'(1 << B_XS)); step(8'(1 << B_XS));
    chk("R5 step", extraPtr, 6);
    chk("R5 rawPtr untouched", rawPtr, 4);
    step(8'((1 << B_XL) | (1 << B_XS)));
    chk("R5 load wins", extraPtr, 4);
  endtask

  task automatic t_read;
    chk("R6 next at 0", readPtrNext, 1);
    step(8'(1 << B_RD));
    chk("R6 readPtr", readPtr, 1);
    chk("R6 next", readPtrNext, 2);
    chk("R7 read frees", freeWords, 29);
    step(8'((1 << B_RD) | (1 << B_WR)));
    chk("R7 read+write freeWords", freeWords, 29);
    chk("R7 read+write readPtr", readPtr, 2);
    chk("R7 read+write rawPtr", rawPtr, 5);
  endtask

  task automatic t_wrap;
    step(8'(1 << B_CM));
    for (int i = 0; i < 3; i++) step(8'(1 << B_RD));
    chk("R7 all read", freeWords, DEPTH);
    for (int i = 0; i < 29; i++) step(8'(1 << B_WR));
    chk("R9 raw wrap", rawPtr, 2);
    chk("R9 freeWords", freeWords, 3);
    step(8'(1 << B_CM));
    chk("R9 commit wrap", commitPtr, 2);
    for (int i = 0; i < 26; i++) step(8'(1 << B_RD));
    chk("R9 readPtr top", readPtr, 31);
    chk("R9 next wraps", readPtrNext, 0);
    for (int i = 0; i < 3; i++) step(8'(1 << B_RD));
    chk("R9 readPtr wrap", readPtr, 2);
    chk("R9 freeWords full", freeWords, DEPTH);
    step(8'(1 << B_XL));
    for (int i = 0; i < 30; i++) step(8'(1 << B_XS));
    chk("R9 extra wrap", extraPtr, 0);
  endtask

  task automatic t_erase;
    step(8'(1 << B_WR)); step(8'(1 << B_XS));
    step(8'((1 << B_ER) | (1 << B_WR) | (1 << B_RD) | (1 << B_XL) | (1 << B_CM)));
    chk("R8 readPtr", readPtr, 0);
    chk("R8 commitPtr", commitPtr, 0);
    chk("R8 rawPtr", rawPtr, 0);
    chk("R8 extraPtr", extraPtr, 0);
    chk("R8 freeWords", freeWords, DEPTH);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_commit();
    t_rollback();
    t_commit_with_write();
    t_extra();
    t_read();
    t_wrap();
    t_erase();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule